// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns one request into the bus cycles that a NAND flash device expects on its media port. The port has a 16-bit bus that carries both addresses and data, two latch-select lines (command latch and address latch), an active-low chip enable, an active-low write strobe, an active-low read strobe and a ready/busy input. A request carries four things: a command byte, up to `NADDR_MAX` address words, a direction, and a word count. The block then issues one command cycle and the address cycles. After that it either loads the write words it takes from a stream, or it waits for the device to report ready and reads words back.

Every setup time, pulse width, hold time and turnaround is a parameter counted in clock cycles, and one down-counter enforces whichever interval is active. The flash commands carry no meaning for the block: it only sequences the cycles. The request side, the write stream and the read results use valid/ready and valid strobes. A single-cycle `done` marks the end of each operation.

Top module: `nand_seq`

## Requirements
- R1: While reset is held, chip enable, write strobe and read strobe are high, both latch lines are low, the bus driver is off, `req_ready` is high, and `done` and `rd_valid` are low.
- R2: The command cycle drives the command latch line high and the address latch line low, with `{8'h00, req_cmd}` on the bus. These lines are stable at least `T_SETUP` cycles before the write strobe falls. The write strobe stays low for exactly `T_WP` cycles. The lines are held at least `T_HOLD` cycles after it rises.
- R3: Exactly `req_naddr` address cycles follow the command cycle, in ascending order. Each one has the address latch line high and the command latch line low. Address cycle i carries `req_addr[16*i +: 16]`. Address cycles use the same setup, pulse and hold timing as the command cycle.
- R4: A write operation loads one word per accepted `wr_valid`/`wr_ready` handshake, in stream order. During a load both latch lines are low. The bus word is stable from `T_SETUP + T_WP` cycles before the write strobe rises until `T_HOLD` cycles after it rises.
- R5: A read operation issues `req_count` read-strobe pulses, each low for exactly `T_RP` cycles, with at least `T_REH` high cycles between pulses. The bus driver stays off while the read strobe is low. The bus is sampled in the last low cycle of each pulse, and the sample appears on `rd_data` with `rd_valid` high in the cycle the strobe returns high.
- R6: The first read strobe of a read operation falls only after `f_rb` has been continuously high for at least `T_RR` cycles. If ready drops again before that, the wait starts over.
- R7: Chip enable is low during every strobe pulse. After the last read of an operation, chip enable returns high exactly `T_CEH_RD` cycles after the read strobe rises.
- R8: When an operation ends on a command, address or load cycle, chip enable returns high no sooner than `T_HOLD + T_CEH_WR` cycles after the last write-strobe rise.
- R9: `done` is high for exactly one cycle per operation: the last cycle before chip enable rises. `req_ready` is high only while chip enable is high.
- R10: A request with `req_count` of zero produces no load or read cycles. A request with `req_naddr` of zero produces no address cycles.
- R11: The write and read strobes are never low together, and the two latch lines are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_cmd | input | 8 | Command byte |
| req_naddr | input | $clog2(NADDR_MAX+1) | Number of address cycles |
| req_addr | input | 16*NADDR_MAX | Address words, word 0 in the low bits |
| req_read | input | 1 | 1 = read operation, 0 = write operation |
| req_count | input | CNT_W | Number of data words |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word taken |
| wr_data | input | 16 | Write word |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | 16 | Read word |
| done | output | 1 | Operation finished pulse |
| f_cle | output | 1 | Command latch select |
| f_ale | output | 1 | Address latch select |
| f_ce_n | output | 1 | Chip enable, active low |
| f_we_n | output | 1 | Write strobe, active low |
| f_re_n | output | 1 | Read strobe, active low |
| f_dq_out | output | 16 | Bus value driven by the sequencer |
| f_dq_oe | output | 1 | Bus driver enable |
| f_dq_in | input | 16 | Bus value from the device |
| f_rb | input | 1 | Device ready (1) or busy (0) |

## Verification
The case hardest to reach from the ports is the ready line rising and then falling again before `T_RR` has elapsed. A premature read strobe would look correct unless the bench tracks when ready last rose. The device model in the bench pulls ready low when the last address cycle of a read completes. On selected reads it follows the busy time with a two-cycle ready blip and a second busy stretch. The bench then measures the spacing from the final ready rise to the first read-strobe fall. The sweep covers every address count and data count of a small configuration in both directions, so the zero-count and zero-address paths and both chip-enable hold rules all occur.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int NADDR_MAX = 4,
  parameter int CNT_W     = 10,
  parameter int TW        = 8,
  parameter int T_SETUP   = 2,
  parameter int T_WP      = 3,
  parameter int T_HOLD    = 1,
  parameter int T_RP      = 3,
  parameter int T_REH     = 2,
  parameter int T_RR      = 4,
  parameter int T_CEH_RD  = 5,
  parameter int T_CEH_WR  = 3,
  localparam int AW = $clog2(NADDR_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [7:0]             req_cmd,
  input  logic [AW-1:0]          req_naddr,
  input  logic [16*NADDR_MAX-1:0] req_addr,
  input  logic                   req_read,
  input  logic [CNT_W-1:0]       req_count,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [15:0]            wr_data,
  output logic                   rd_valid,
  output logic [15:0]            rd_data,
  output logic                   done,
  output logic                   f_cle,
  output logic                   f_ale,
  output logic                   f_ce_n,
  output logic                   f_we_n,
  output logic                   f_re_n,
  output logic [15:0]            f_dq_out,
  output logic                   f_dq_oe,
  input  logic [15:0]            f_dq_in,
  input  logic                   f_rb
);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_WLOW, S_WHOLD, S_FETCH,
    S_WAITRB, S_RRDY, S_RLOW, S_RHIGH, S_CEH
  } st_t;

  localparam logic [1:0] K_CMD = 2'd0, K_ADDR = 2'd1, K_DATA = 2'd2;

  st_t                   st;
  logic [TW-1:0]         cnt;
  logic [1:0]            kind;
  logic [AW-1:0]         aidx, nad;
  logic [16*NADDR_MAX-1:0] addr_q;
  logic [CNT_W-1:0]      left;
  logic                  is_rd;
  logic [15:0]           dq_r;
  logic [AW-1:0]         nxt_idx;
  logic                  more_addr;
  logic                  wcyc;

  assign nxt_idx   = (kind == K_CMD) ? '0 : aidx + 1'b1;
  assign more_addr = (kind != K_DATA) && (nxt_idx < nad);
  assign wcyc      = (st == S_SETUP) || (st == S_WLOW) || (st == S_WHOLD);

  assign f_cle     = wcyc && (kind == K_CMD);
  assign f_ale     = wcyc && (kind == K_ADDR);
  assign f_dq_oe   = wcyc;
  assign f_dq_out  = dq_r;
  assign f_we_n    = (st != S_WLOW);
  assign f_re_n    = (st != S_RLOW);
  assign f_ce_n    = (st == S_IDLE);
  assign req_ready = (st == S_IDLE);
  assign wr_ready  = (st == S_FETCH);
  assign done      = (st == S_CEH) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; kind <= K_CMD; aidx <= '0; nad <= '0;
      addr_q <= '0; left <= '0; is_rd <= 1'b0; dq_r <= '0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          is_rd <= req_read; nad <= req_naddr; addr_q <= req_addr;
          left <= req_count; dq_r <= {8'h00, req_cmd}; kind <= K_CMD;
          aidx <= '0; st <= S_SETUP; cnt <= TW'(T_SETUP - 1);
        end
        S_SETUP: if (cnt == '0) begin st <= S_WLOW; cnt <= TW'(T_WP - 1); end
                 else cnt <= cnt - 1'b1;
        S_WLOW:  if (cnt == '0) begin st <= S_WHOLD; cnt <= TW'(T_HOLD - 1); end
                 else cnt <= cnt - 1'b1;
        S_WHOLD: if (cnt != '0) cnt <= cnt - 1'b1;
          else if (more_addr) begin
            aidx <= nxt_idx; kind <= K_ADDR;
            dq_r <= 16'(addr_q >> {nxt_idx, 4'b0000});
            st <= S_SETUP; cnt <= TW'(T_SETUP - 1);
          end else if (kind == K_DATA) begin
            left <= left - 1'b1;
            if (left == CNT_W'(1)) begin st <= S_CEH; cnt <= TW'(T_CEH_WR - 1); end
            else st <= S_FETCH;
          end else if (left == '0) begin
            st <= S_CEH; cnt <= TW'(T_CEH_WR - 1);
          end else if (is_rd) st <= S_WAITRB;
          else begin kind <= K_DATA; st <= S_FETCH; end
        S_FETCH: if (wr_valid) begin
          dq_r <= wr_data; st <= S_SETUP; cnt <= TW'(T_SETUP - 1);
        end
        S_WAITRB: if (f_rb) begin st <= S_RRDY; cnt <= TW'(T_RR - 1); end
        S_RRDY: if (!f_rb) st <= S_WAITRB;
          else if (cnt == '0) begin st <= S_RLOW; cnt <= TW'(T_RP - 1); end
          else cnt <= cnt - 1'b1;
        S_RLOW: if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            rd_data <= f_dq_in; rd_valid <= 1'b1; left <= left - 1'b1;
            if (left == CNT_W'(1)) begin st <= S_CEH; cnt <= TW'(T_CEH_RD - 1); end
            else begin st <= S_RHIGH; cnt <= TW'(T_REH - 1); end
          end
        S_RHIGH: if (cnt == '0) begin st <= S_RLOW; cnt <= TW'(T_RP - 1); end
                 else cnt <= cnt - 1'b1;
        S_CEH:   if (cnt == '0) st <= S_IDLE;
                 else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!f_we_n && !f_re_n)); // R11
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(f_cle && f_ale)); // R11
  AST_LINES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !f_we_n |=> ($stable(f_cle) && $stable(f_ale) && $stable(f_dq_out))); // R4
  AST_RE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(f_re_n) |-> $past(f_rb)); // R6
  AST_CE_COVERS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_we_n || !f_re_n) |-> !f_ce_n); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && f_ce_n)); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> f_ce_n); // R9

endmodule

// File: tb/nand_seq_test.sv
module nand_seq_test;
  localparam int NA = 4, CW = 10;
  localparam int TS = 2, TWP = 3, TH = 1, TRP = 3, TREH = 2, TRR = 4, TCR = 5, TCW = 3;
  localparam int AW = $clog2(NA + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, req_read = 1'b0, wr_valid = 1'b0;
  logic [7:0] req_cmd = '0;
  logic [AW-1:0] req_naddr = '0;
  logic [16*NA-1:0] req_addr = '0;
  logic [CW-1:0] req_count = '0;
  logic [15:0] wr_data = '0;
  logic req_ready, wr_ready, rd_valid, done;
  logic [15:0] rd_data, f_dq_out, f_dq_in;
  logic f_cle, f_ale, f_ce_n, f_we_n, f_re_n, f_dq_oe, f_rb;

  nand_seq #(.NADDR_MAX(NA), .CNT_W(CW), .T_SETUP(TS), .T_WP(TWP), .T_HOLD(TH),
    .T_RP(TRP), .T_REH(TREH), .T_RR(TRR), .T_CEH_RD(TCR), .T_CEH_WR(TCW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_naddr(req_naddr), .req_addr(req_addr), .req_read(req_read),
    .req_count(req_count), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .f_cle(f_cle), .f_ale(f_ale),
    .f_ce_n(f_ce_n), .f_we_n(f_we_n), .f_re_n(f_re_n), .f_dq_out(f_dq_out),
    .f_dq_oe(f_dq_oe), .f_dq_in(f_dq_in), .f_rb(f_rb));

  int checks = 0, fails = 0, op = 0;
  int cyc, last_ctl, last_wf, last_wr, last_rf, last_rr, rb_since;
  int ridx, ln, rn, done_cnt, addr_seen, busy_left, blip_left;
  bit tb_rd, tb_gl;
  int tb_na, tb_busy;
  logic [1:0]  lk [64];
  logic [15:0] ld [64];
  logic [15:0] rdl [64];
  logic [18:0] p_ctl;
  logic p_we, p_re, p_ce, p_rb, p_done;

  function automatic logic [15:0] rpat(int i);
    return 16'(32'h3C00 + i * 32'h0107 + op * 32'h0011);
  endfunction
  function automatic logic [15:0] wpat(int i);
    return 16'(32'h5A00 ^ (i * 37) ^ (op * 32'h0100));
  endfunction
  function automatic logic [15:0] apat(int i);
    return 16'(32'h0A00 + i * 32'h0010 + op);
  endfunction

  assign f_dq_in = !f_re_n ? rpat(ridx) : 16'hDEAD;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      f_rb = 1'b1; cyc = 0; last_ctl = -1000; last_wf = -1000; last_wr = -1000;
      last_rf = -1000; last_rr = -1000; rb_since = -1000; busy_left = 0; blip_left = 0;
      p_ctl = '0; p_we = 1'b1; p_re = 1'b1; p_ce = 1'b1; p_rb = 1'b1; p_done = 1'b0;
    end else begin
      cyc++;
      if ({f_cle, f_ale, f_dq_oe, f_dq_out} !== p_ctl) begin
        chk(cyc - last_wr >= TH, "R2 hold after WE# rise", cyc - last_wr, TH);
        last_ctl = cyc;
      end
      if (p_we && !f_we_n) begin
        chk(cyc - last_ctl >= TS, "R4 setup before WE# fall", cyc - last_ctl, TS);
        last_wf = cyc;
      end
      if (!p_we && f_we_n) begin
        chk(cyc - last_wf == TWP, "R2 WE# low width", cyc - last_wf, TWP);
        last_wr = cyc;
        lk[ln] = {f_cle, f_ale}; ld[ln] = f_dq_out; ln++;
        if (f_ale) addr_seen++;
        if (tb_rd && tb_busy > 0 && ((f_cle && tb_na == 0) || (f_ale && addr_seen == tb_na))) begin
          busy_left = tb_busy; blip_left = tb_gl ? 2 : 0;
        end
      end
      if (!f_we_n && !f_re_n) chk(1'b0, "R11 strobes overlap", 1, 0);
      if (f_cle && f_ale) chk(1'b0, "R11 latch lines overlap", 1, 0);
      if (p_re && !f_re_n) begin
        chk(f_rb && (cyc - rb_since >= TRR), "R6 ready-to-RE# spacing", cyc - rb_since, TRR);
        if (rn > 0) chk(cyc - last_rr >= TREH, "R5 RE# high time", cyc - last_rr, TREH);
        chk(!f_dq_oe && !f_ce_n, "R5 bus released, R7 CE# low", f_dq_oe, 0);
        last_rf = cyc;
      end
      if (!p_re && f_re_n) begin
        chk(cyc - last_rf == TRP, "R5 RE# low width", cyc - last_rf, TRP);
        chk(rd_valid, "R5 rd_valid with RE# rise", rd_valid, 1);
        last_rr = cyc; ridx++;
      end
      if (rd_valid) begin rdl[rn] = rd_data; rn++; end
      if (!p_ce && f_ce_n) begin
        chk(p_done, "R9 done before CE# rise", p_done, 1);
        if (rn > 0) chk(cyc - last_rr == TCR, "R7 CE# hold after read", cyc - last_rr, TCR);
        else chk(cyc - last_wr >= TH + TCW, "R8 CE# hold after write", cyc - last_wr, TH + TCW);
      end
      if (done) done_cnt++;
      if (busy_left > 0) begin f_rb = 1'b0; busy_left--; end
      else if (blip_left > 0) begin
        f_rb = 1'b1; blip_left--;
        if (blip_left == 0) busy_left = 3;
      end else f_rb = 1'b1;
      if (f_rb && !p_rb) rb_since = cyc;
      p_ctl = {f_cle, f_ale, f_dq_oe, f_dq_out};
      p_we = f_we_n; p_re = f_re_n; p_ce = f_ce_n; p_rb = f_rb; p_done = done;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic run_op(input bit rd, input int na, input int cnt, input int busy, input bit gl);
    logic [7:0] cmd;
    op++;
    cmd = rd ? 8'h30 : 8'(8'h80 ^ op);
    tb_rd = rd; tb_na = na; tb_busy = busy; tb_gl = gl;
    ln = 0; rn = 0; ridx = 0; addr_seen = 0; done_cnt = 0;
    @(negedge clk);
    req_cmd = cmd; req_naddr = AW'(na); req_read = rd; req_count = CW'(cnt);
    for (int i = 0; i < NA; i++) req_addr[16*i +: 16] = apat(i);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!f_ce_n, "R9 request accepted, CE# low", f_ce_n, 0);
    if (!rd) for (int i = 0; i < cnt; i++) begin
      wr_data = wpat(i); wr_valid = 1'b1;
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      if (i % 2 == 1) repeat (2) @(negedge clk);
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(done_cnt == 1, "R9 single done", done_cnt, 1);
    chk(ln == 1 + na + (rd ? 0 : cnt), "R10 write-strobe cycle count", ln, 1 + na + (rd ? 0 : cnt));
    chk(lk[0] == 2'b10 && ld[0] == {8'h00, cmd}, "R2 command cycle", int'(ld[0]), int'(cmd));
    for (int i = 0; i < na && 1 + i < ln; i++)
      chk(lk[1+i] == 2'b01 && ld[1+i] == apat(i), "R3 address cycle", int'(ld[1+i]), int'(apat(i)));
    if (!rd) for (int i = 0; i < cnt && 1 + na + i < ln; i++)
      chk(lk[1+na+i] == 2'b00 && ld[1+na+i] == wpat(i), "R4 load cycle", int'(ld[1+na+i]), int'(wpat(i)));
    chk(rn == (rd ? cnt : 0), "R10 read word count", rn, rd ? cnt : 0);
    if (rd) for (int i = 0; i < cnt && i < rn; i++)
      chk(rdl[i] == rpat(i), "R5 read data", int'(rdl[i]), int'(rpat(i)));
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(f_ce_n && f_we_n && f_re_n && !f_cle && !f_ale && !f_dq_oe && req_ready && !done && !rd_valid,
        "R1 reset state", {f_ce_n, f_we_n, f_re_n, f_cle, f_ale, f_dq_oe, req_ready, done}, 8'b11100010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int rd = 0; rd < 2; rd++)
      for (int na = 0; na <= NA; na++)
        for (int cnt = 0; cnt < 4; cnt++)
          run_op(rd[0], na, cnt, rd == 0 ? 0 : (na == 1 ? 0 : 1 + ((na + cnt) % 3) * 3),
                 rd == 1 && cnt == 2 && na != 1);
    run_op(1'b1, 3, 8, 6, 1'b1);
    run_op(1'b0, 2, 6, 0, 1'b0);
    summary();
  end
endmodule